// File: doc/BRIEF.md
# Internal Data Memory Access Unit

This block is the byte-wide data memory of a small 8-bit microcontroller core. It holds a 256-byte internal RAM and a small set of special function registers (SFRs). Both sit in one 8-bit address space. Every request carries an access mode, an 8-bit address, read and write strobes and write data. The block resolves the request to a RAM byte or to an SFR, applies the working-register bank alias, and keeps the stack pointer current for push and pop.

The upper half of the address space resolves according to the mode. Direct requests to 0x80–0xFF land on the SFRs. Indirect and stack requests to the same addresses land on the upper 128 bytes of RAM. Working registers R0–R7 live in one of four 8-byte banks at the bottom of RAM. Two bits of the status register select the active bank.

The implemented SFRs are the accumulator, B, status, stack pointer and the two data pointer bytes. The stack pointer changes on push and pop. The other SFRs are plain storage.

Top module: `idata_unit`

## Requirements
- R1: A direct request (mode 2'b00) with address 0x00–0x7F reads or writes RAM at that address.
- R2: A direct request with address 0x80–0xFF targets an SFR and never RAM. The SFR addresses are: stack pointer 0x81, data pointer low 0x82, data pointer high 0x83, status 0xD0, accumulator 0xE0, B 0xF0. Each of these reads back the last value written.
- R3: An indirect (mode 2'b10) or stack (mode 2'b11) request whose resolved address is 0x80–0xFF reaches upper RAM and leaves every SFR unchanged.
- R4: A register request (mode 2'b01) for register n = addr[2:0] reaches RAM address bank*8 + n, where bank is status bits [4:3].
- R5: An indirect request uses as its RAM address the content of R0 (addr[0] = 0) or R1 (addr[0] = 1) of the currently active bank.
- R6: A synchronous active-low reset sets the stack pointer to 0x07, sets the other SFRs to 0x00 and clears the read data output.
- R7: A stack write (push) first increments the stack pointer modulo 256 and then writes the data to RAM at the new stack pointer.
- R8: A stack read (pop) returns RAM at the current stack pointer and then decrements the stack pointer modulo 256.
- R9: A direct read of an SFR address with no implemented register returns 0x00. A direct write to such an address changes nothing.
- R10: Read data appears on rdata one clock after the read request. It holds its value in every cycle without an accepted read. Writes take effect at the rising clock edge.
- R11: A request with both strobes high is performed as a write only, so a stack request pushes and does not pop. rdata keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Access mode: 00 direct, 01 register, 10 indirect, 11 stack |
| addr | input | 8 | Address, register number (bits 2:0) or pointer select (bit 0) |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
The hardest situation to reach from the ports is a stack or indirect access into the upper 128 bytes, because that data shares addresses with the SFRs. The stimulus sets the stack pointer directly to 0x7F and pushes, so the data lands at 0x80. It also loads R0 or R1 of a non-zero bank with a pointer above 0x7F and accesses through that pointer. In both cases the bench reads back the accumulator and other SFRs to show they are untouched, then reads the byte back indirectly to show it went to RAM. The stack pointer is also walked across 0xFF and back to check wrap-around in both directions.

// File: rtl/idata_pkg.sv
// Shared encodings for the internal data memory access unit.
// Assumes an 8-bit address space and byte-wide data throughout.
package idata_pkg;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int RAM_DEPTH = 1 << AW;

    typedef enum logic [1:0] {
        ACC_DIRECT   = 2'b00,
        ACC_REGISTER = 2'b01,
        ACC_INDIRECT = 2'b10,
        ACC_STACK    = 2'b11
    } acc_mode_e;

    localparam logic [AW-1:0] SFR_SP   = 8'h81;
    localparam logic [AW-1:0] SFR_DPL  = 8'h82;
    localparam logic [AW-1:0] SFR_DPH  = 8'h83;
    localparam logic [AW-1:0] SFR_PSW  = 8'hD0;
    localparam logic [AW-1:0] SFR_ACC  = 8'hE0;
    localparam logic [AW-1:0] SFR_B    = 8'hF0;
    localparam logic [DW-1:0] SP_RESET = 8'h07;
endpackage

// File: rtl/idata_addr_map.sv
// Resolves a request to either an SFR or a RAM byte address.
// Assumes the pointer byte for indirect mode is read combinationally
// from RAM at ptr_addr by the caller.
module idata_addr_map
    import idata_pkg::*;
(
    input  logic [1:0]    mode,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    bank,
    input  logic [DW-1:0] sp,
    input  logic [DW-1:0] ptr,
    output logic [AW-1:0] ptr_addr,
    output logic [AW-1:0] ram_addr,
    output logic          is_sfr,
    output logic          push,
    output logic          pop
);
    localparam int PAD = AW - 5;

    // Address of R0/R1 in the active bank, used as the indirect pointer.
    assign ptr_addr = {{PAD{1'b0}}, bank, 2'b00, addr[0]};

    // Mode-dependent target selection.
    always_comb begin
        is_sfr   = 1'b0;
        ram_addr = addr;
        unique case (acc_mode_e'(mode))
            ACC_DIRECT:   is_sfr = addr[AW-1];
            ACC_REGISTER: ram_addr = {{PAD{1'b0}}, bank, addr[2:0]};
            ACC_INDIRECT: ram_addr = ptr;
            ACC_STACK:    ram_addr = wr_en ? sp + 8'd1 : sp;
            default:      ram_addr = addr;
        endcase
    end

    // Stack operations; a write strobe takes precedence over a read.
    assign push = (mode == ACC_STACK) && wr_en;
    assign pop  = (mode == ACC_STACK) && rd_en && !wr_en;
endmodule

// File: rtl/idata_ram.sv
// 256-byte internal RAM with one write port and two async read ports.
// Assumes contents are not cleared by reset; rst_n only gates checks.
module idata_ram
    import idata_pkg::*;
#(
    parameter int DEPTH = RAM_DEPTH,
    parameter int WIDTH = DW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr_a,
    output logic [WIDTH-1:0]         rdata_a,
    input  logic [$clog2(DEPTH)-1:0] raddr_b,
    output logic [WIDTH-1:0]         rdata_b
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Byte write on the rising edge.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Combinational reads for data and pointer.
    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

    // R1
    ram_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/idata_sfr.sv
// Special function register bank: ACC, B, PSW, SP, DPL, DPH.
// Assumes push/pop never coincide with a direct SFR write.
// Unimplemented addresses read zero and ignore writes.
module idata_sfr
    import idata_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          push,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] sp,
    output logic [1:0]    bank
);
    logic [DW-1:0] acc_q, b_q, psw_q, dpl_q, dph_q, sp_q;

    // Storage SFR writes and reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0; b_q <= '0; psw_q <= '0; dpl_q <= '0; dph_q <= '0;
        end else if (we) begin
            case (addr)
                SFR_ACC: acc_q <= wdata;
                SFR_B:   b_q   <= wdata;
                SFR_PSW: psw_q <= wdata;
                SFR_DPL: dpl_q <= wdata;
                SFR_DPH: dph_q <= wdata;
                default: ;
            endcase
        end
    end

    // Stack pointer: push pre-increments, pop post-decrements, or direct write.
    always_ff @(posedge clk) begin
        if (!rst_n)                       sp_q <= SP_RESET;
        else if (push)                    sp_q <= sp_q + 8'd1;
        else if (pop)                     sp_q <= sp_q - 8'd1;
        else if (we && addr == SFR_SP)    sp_q <= wdata;
    end

    // Read mux; holes read as zero.
    always_comb begin
        case (addr)
            SFR_ACC: rdata = acc_q;
            SFR_B:   rdata = b_q;
            SFR_PSW: rdata = psw_q;
            SFR_DPL: rdata = dpl_q;
            SFR_DPH: rdata = dph_q;
            SFR_SP:  rdata = sp_q;
            default: rdata = '0;
        endcase
    end

    assign sp   = sp_q;
    assign bank = psw_q[4:3];

    // R6
    sp_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> sp_q == SP_RESET);
    // R7
    push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> sp_q == $past(sp_q) + 8'd1);
    // R8
    pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> sp_q == $past(sp_q) - 8'd1);
    // R3
    sfr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !push && !pop) |=> $stable({acc_q, b_q, psw_q, dpl_q, dph_q, sp_q}));
endmodule

// File: rtl/idata_unit.sv
// Internal data memory access unit: routes direct, register, indirect
// and stack requests to RAM or SFRs and registers the read data.
// Assumes one request per cycle with no back-pressure.
module idata_unit
    import idata_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [AW-1:0] ptr_addr, ram_addr;
    logic [DW-1:0] ptr_byte, ram_rd, sfr_rd, sp;
    logic [1:0]    bank;
    logic          is_sfr, push, pop, rd_take;
    logic [DW-1:0] rdata_q;

    idata_addr_map u_map (
        .mode(mode), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .bank(bank), .sp(sp), .ptr(ptr_byte),
        .ptr_addr(ptr_addr), .ram_addr(ram_addr), .is_sfr(is_sfr),
        .push(push), .pop(pop)
    );

    idata_ram u_ram (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && !is_sfr), .waddr(ram_addr), .wdata(wdata),
        .raddr_a(ram_addr), .rdata_a(ram_rd),
        .raddr_b(ptr_addr), .rdata_b(ptr_byte)
    );

    idata_sfr u_sfr (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && is_sfr), .addr(addr), .wdata(wdata),
        .push(push), .pop(pop),
        .rdata(sfr_rd), .sp(sp), .bank(bank)
    );

    assign rd_take = rd_en && !wr_en;

    // Registered read data, held when no read is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_take) rdata_q <= is_sfr ? sfr_rd : ram_rd;
    end

    assign rdata = rdata_q;

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_take |=> $stable(rdata_q));
    // R3
    upper_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != ACC_DIRECT) |-> !is_sfr);
endmodule

// File: tb/idata_unit_tb.sv
module idata_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [7:0] addr = 8'h00;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    idata_unit u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata)
    );

    typedef struct packed {
        logic [1:0] m;
        logic       rd;
        logic       wr;
        logic [7:0] a;
        logic [7:0] d;
        logic       chk;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{2'd0,1'b1,1'b0,8'h81,8'h00,1'b1,8'h07,4'd6},  // R6 SP reset
        '{2'd0,1'b1,1'b0,8'hE0,8'h00,1'b1,8'h00,4'd6},  // R6 ACC reset
        '{2'd0,1'b0,1'b1,8'h10,8'h5A,1'b0,8'h00,4'd1},
        '{2'd0,1'b1,1'b0,8'h10,8'h00,1'b1,8'h5A,4'd1},  // R1
        '{2'd0,1'b0,1'b1,8'h90,8'h33,1'b0,8'h00,4'd9},
        '{2'd0,1'b1,1'b0,8'h90,8'h00,1'b1,8'h00,4'd9},  // R9
        '{2'd0,1'b0,1'b1,8'hE0,8'hA1,1'b0,8'h00,4'd2},
        '{2'd0,1'b1,1'b0,8'hE0,8'h00,1'b1,8'hA1,4'd2},  // R2 ACC
        '{2'd0,1'b0,1'b1,8'h00,8'hE0,1'b0,8'h00,4'd5},  // bank0 R0 = 0xE0
        '{2'd2,1'b0,1'b1,8'h00,8'h77,1'b0,8'h00,4'd3},  // RAM[E0] = 77
        '{2'd0,1'b1,1'b0,8'hE0,8'h00,1'b1,8'hA1,4'd3},  // R3 ACC untouched
        '{2'd2,1'b1,1'b0,8'h00,8'h00,1'b1,8'h77,4'd5},  // R5 via R0
        '{2'd0,1'b0,1'b1,8'hD0,8'h18,1'b0,8'h00,4'd4},  // bank 3
        '{2'd1,1'b0,1'b1,8'h02,8'h4C,1'b0,8'h00,4'd4},  // R2 of bank3 -> 0x1A
        '{2'd0,1'b1,1'b0,8'h1A,8'h00,1'b1,8'h4C,4'd4},  // R4
        '{2'd0,1'b1,1'b0,8'hD0,8'h00,1'b1,8'h18,4'd2},  // R2 PSW
        '{2'd0,1'b0,1'b1,8'h19,8'hC0,1'b0,8'h00,4'd5},  // bank3 R1 = 0xC0
        '{2'd2,1'b0,1'b1,8'h01,8'h3E,1'b0,8'h00,4'd5},
        '{2'd0,1'b1,1'b0,8'hC0,8'h00,1'b1,8'h00,4'd9},  // 0xC0 direct is a hole
        '{2'd2,1'b1,1'b0,8'h01,8'h00,1'b1,8'h3E,4'd5},  // R5 via R1 bank3
        '{2'd3,1'b0,1'b1,8'h00,8'h91,1'b0,8'h00,4'd7},  // push
        '{2'd0,1'b1,1'b0,8'h81,8'h00,1'b1,8'h08,4'd7},  // R7 SP
        '{2'd0,1'b1,1'b0,8'h08,8'h00,1'b1,8'h91,4'd7},  // R7 data
        '{2'd3,1'b1,1'b0,8'h00,8'h00,1'b1,8'h91,4'd8},  // R8 pop data
        '{2'd0,1'b1,1'b0,8'h81,8'h00,1'b1,8'h07,4'd8},  // R8 SP
        '{2'd0,1'b0,1'b1,8'h82,8'h12,1'b0,8'h00,4'd2},
        '{2'd0,1'b0,1'b1,8'h83,8'h34,1'b0,8'h00,4'd2},
        '{2'd0,1'b1,1'b0,8'h82,8'h00,1'b1,8'h12,4'd2},  // R2 DPL
        '{2'd0,1'b1,1'b0,8'h83,8'h00,1'b1,8'h34,4'd2}   // R2 DPH
    };

    task automatic op(input logic [1:0] m, input logic r, input logic w,
                      input logic [7:0] a, input logic [7:0] d);
        mode = m; rd_en = r; wr_en = w; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic check(input logic [7:0] exp, input int req, input string what);
        checks++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %02h expected %02h", req, what, rdata, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(8'h00, 6, "rdata under reset");   // R6
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            op(VEC[i].m, VEC[i].rd, VEC[i].wr, VEC[i].a, VEC[i].d);
            if (VEC[i].chk) check(VEC[i].exp, int'(VEC[i].req), $sformatf("vector %0d", i));
        end

        // R10: idle cycles hold the last read
        op(2'd0, 1'b0, 1'b0, 8'h10, 8'h00);
        op(2'd0, 1'b0, 1'b1, 8'h10, 8'hEE);
        check(8'h34, 10, "rdata held across idle and write");

        // R11: both strobes -> write only, rdata holds
        op(2'd0, 1'b1, 1'b1, 8'h20, 8'h99);
        check(8'h34, 11, "rdata held on rd+wr");
        op(2'd0, 1'b1, 1'b0, 8'h20, 8'h00);
        check(8'h99, 11, "rd+wr performed write");
        op(2'd3, 1'b1, 1'b1, 8'h00, 8'h55);     // push only, SP 07->08
        op(2'd0, 1'b1, 1'b0, 8'h81, 8'h00);
        check(8'h08, 11, "stack rd+wr pushes");

        // R3: push into upper RAM from SP = 0x7F
        op(2'd0, 1'b0, 1'b1, 8'h81, 8'h7F);
        op(2'd3, 1'b0, 1'b1, 8'h00, 8'h2D);
        op(2'd0, 1'b1, 1'b0, 8'hE0, 8'h00);
        check(8'hA1, 3, "ACC after upper push");
        op(2'd0, 1'b0, 1'b1, 8'h18, 8'h80);     // bank3 R0 = 0x80
        op(2'd2, 1'b1, 1'b0, 8'h00, 8'h00);
        check(8'h2D, 3, "upper RAM 0x80 via pointer");

        // R7/R8: wrap at 0xFF
        op(2'd0, 1'b0, 1'b1, 8'h81, 8'hFF);
        op(2'd3, 1'b0, 1'b1, 8'h00, 8'h6B);
        op(2'd0, 1'b1, 1'b0, 8'h81, 8'h00);
        check(8'h00, 7, "SP wraps to 00");
        op(2'd0, 1'b1, 1'b0, 8'h00, 8'h00);
        check(8'h6B, 7, "push wrote RAM 00");
        op(2'd3, 1'b1, 1'b0, 8'h00, 8'h00);
        check(8'h6B, 8, "pop at SP 00");
        op(2'd0, 1'b1, 1'b0, 8'h81, 8'h00);
        check(8'hFF, 8, "SP wraps to FF");

        // R6: reset mid-run
        rst_n = 1'b0;
        op(2'd0, 1'b0, 1'b0, 8'h00, 8'h00);
        rst_n = 1'b1;
        op(2'd0, 1'b1, 1'b0, 8'h81, 8'h00);
        check(8'h07, 6, "SP after reset");
        op(2'd0, 1'b1, 1'b0, 8'hD0, 8'h00);
        check(8'h00, 6, "PSW after reset");
        op(2'd0, 1'b1, 1'b0, 8'hF0, 8'h00);
        check(8'h00, 6, "B after reset");

        finish_run();
    end
endmodule